// File: doc/BRIEF.md
# Serial Flash Command Responder

This block is the device side of a serial flash on a four-wire SPI bus. It works in both clock polarities that keep data sampled on the rising edge: idle-low (mode 0) and idle-high (mode 3). The host pulls chip enable low and shifts an 8-bit opcode in MSB first on the serial input. The block then serves one of these commands:

- a continuous array read, which takes a 24-bit address and streams bytes until deselect, wrapping at the top of the array;
- a fixed three-byte identification answer;
- a status read;
- write enable;
- enable-write-status;
- a status write.

The status write is guarded by an interlock. It is accepted only in the bus cycle that comes directly after a completed write enable or enable-write-status command.

The array is a small on-chip byte store with a power-of-two depth, set by a parameter. It stands in for real memory. A test preload port fills it. The serial pins are oversampled by the block's system clock. The output pin is given as a data bit plus a drive enable, and the pad ring builds the tri-state buffer from them.

Top module: `sflash_responder`

## Requirements
- R1: Opcode 03h followed by an address sent MSB first (ADDR_W = 24 bits by default) starts a read. Bytes then come out of `so` MSB first from array index (address mod 2^IDX_W). Each bit changes after a falling SCK and is valid for the host's next rising SCK.
- R2: A read continues without limit while `ce_n` stays low, and the index steps up by one after each byte. After index 2^IDX_W-1 the next byte comes from index 0.
- R3: Address bits at and above bit IDX_W have no effect on which byte is returned.
- R4: Opcode 9Fh returns the bytes 8Ch, 20h, 13h in that order, and the three then repeat for as long as the host keeps clocking.
- R5: `so_oe` is 0 in each of these cases: while `ce_n` is high, during the opcode and address bits, and for a whole cycle whose opcode is not recognised.
- R6: Opcode 06h, completed by `ce_n` rising after exactly 8 bits, sets the write-enable latch. Opcode 05h returns the status byte {stored bits [7:2], write-enable latch in bit 1, 0 in bit 0}.
- R7: Opcode 01h with exactly 8 data bits, in the bus cycle directly after a completed 06h or 50h, loads data bits [7:2] into the status byte and clears the write-enable latch. Data bits [1:0] are discarded.
- R8: A status write in any other cycle leaves the status byte unchanged. This includes a write after some other cycle has come between it and the enable, and a write cut short before 8 data bits.
- R9: Opcode 50h permits the next status write but does not set the write-enable latch.
- R10: A rising `ce_n` in the middle of an opcode, or after extra bits beyond a complete command, cancels that command. The next cycle decodes a fresh opcode.
- R11: Every command behaves the same with SCK idling high (mode 3) as with SCK idling low (mode 0).
- R12: After reset the status byte and the write-enable latch are 0 and `so_oe` is 0.
- R13: A write on the preload port places its byte at the given index, and later reads return that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| ce_n | input | 1 | Chip enable, active low |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for `so`; 0 means high impedance |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | IDX_W | Preload array index |
| pl_data | input | 8 | Preload byte |

## Verification
Each serial pin passes through two synchroniser stages before an edge is detected. A new `so` bit is therefore registered on the third system clock after a falling SCK, and the bench samples `so` and `so_oe` six system clocks after that fall, just before it raises SCK. Write enable, permission and status updates are committed on the third system clock after `ce_n` rises. The bench waits eight clocks after every deselect before it starts the next command, and it then reads the effect back through a status read. The data bytes expected from each read are computed from the preload pattern, with the index wrapped modulo the array depth.

// File: rtl/sflash_pkg.sv
// sflash_pkg: shared opcodes, identification bytes and the command state type
// for the serial flash responder. Assumes 8-bit opcodes sent MSB first.
package sflash_pkg;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_ID    = 8'h9F;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_EWSR  = 8'h50;
    localparam logic [7:0] OP_WRSR  = 8'h01;

    localparam logic [7:0] ID_MFR   = 8'h8C;
    localparam logic [7:0] ID_TYPE  = 8'h20;
    localparam logic [7:0] ID_CAP   = 8'h13;

    typedef enum logic [3:0] {
        ST_OPC,        // shifting in the opcode
        ST_ADDR,       // shifting in the read address
        ST_READ,       // streaming array bytes
        ST_ID,         // streaming identification bytes
        ST_RDSR,       // streaming the status byte
        ST_WEN,        // write enable complete, waiting for deselect
        ST_EWS,        // enable-write-status complete, waiting for deselect
        ST_WRSR,       // shifting in the status data byte
        ST_WRSR_DONE,  // status data complete, waiting for deselect
        ST_IGNORE      // unknown or over-long command, no effect
    } sfr_state_e;
endpackage

// File: rtl/sfr_bus_frontend.sv
// sfr_bus_frontend: brings sck, ce_n and si into the clk domain and produces
// single-cycle pulses for serial clock edges while selected and for deselect.
// Assumes clk is at least four times faster than sck. si goes through the
// same number of stages as sck, so it stays aligned with the rising pulse.
module sfr_bus_frontend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic ce_n,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic ce_rise,
    output logic ce_s,
    output logic si_s
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sck_p, ce_p, si_p;
    logic sck_d, ce_d;

    // synchroniser chains for the three serial inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p <= '0;
            ce_p  <= '1;
            si_p  <= '0;
        end else begin
            sck_p <= {sck_p[SYNC_STAGES-2:0], sck};
            ce_p  <= {ce_p[SYNC_STAGES-2:0], ce_n};
            si_p  <= {si_p[SYNC_STAGES-2:0], si};
        end
    end

    // delayed copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            ce_d  <= 1'b1;
        end else begin
            sck_d <= sck_p[LAST];
            ce_d  <= ce_p[LAST];
        end
    end

    // edge pulses, serial clock edges only count while selected
    always_comb begin
        ce_s     = ce_p[LAST];
        si_s     = si_p[LAST];
        sck_rise = sck_p[LAST] & ~sck_d & ~ce_s;
        sck_fall = ~sck_p[LAST] & sck_d & ~ce_s;
        ce_rise  = ce_s & ~ce_d;
    end
endmodule

// File: rtl/sfr_storage.sv
// sfr_storage: byte array that stands in for the flash memory. Written only
// through the preload port and read combinationally at the current index.
// Contents are not cleared by reset.
module sfr_storage #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             pl_we,
    input  logic [IDX_W-1:0] pl_addr,
    input  logic [7:0]       pl_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] mem [DEPTH];

    // preload write
    always_ff @(posedge clk) begin
        if (pl_we) mem[pl_addr] <= pl_data;
    end

    // read of the byte at the current index
    always_comb rd_data = mem[rd_idx];
endmodule

// File: rtl/sfr_cmd_engine.sv
// sfr_cmd_engine: counts rising serial clock edges, decodes the opcode,
// collects the address and status data, keeps the read index, the
// write-enable latch, the status-write permission and the status bits.
// It offers the byte to send plus the bit position. Commands that change
// state are committed only on deselect.
module sfr_cmd_engine
    import sflash_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_rise,
    input  logic             ce_rise,
    input  logic             ce_s,
    input  logic             si_s,
    input  logic [7:0]       mem_byte,
    output logic [IDX_W-1:0] mem_idx,
    output logic [7:0]       tx_byte,
    output logic [2:0]       bit_sel,
    output logic             drive_en
);
    localparam int CNT_W = $clog2(ADDR_W) + 1;
    localparam logic [CNT_W-1:0] CNT_ZERO  = '0;
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(1);

    sfr_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       shreg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       id_sel_q;
    logic [7:0]       wr_data_q;
    logic [5:0]       sr_q;
    logic             wel_q;
    logic             perm_q;

    logic [7:0]        in_byte;
    logic [ADDR_W-1:0] in_addr;

    // incoming byte and address including the bit sampled this edge
    always_comb begin
        in_byte = {shreg_q[6:0], si_s};
        in_addr = {addr_q[ADDR_W-2:0], si_s};
    end

    // command sequencing on serial clock edges, commit on deselect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OPC;
            cnt_q     <= CNT_ZERO;
            shreg_q   <= '0;
            addr_q    <= '0;
            idx_q     <= '0;
            id_sel_q  <= '0;
            wr_data_q <= '0;
            sr_q      <= '0;
            wel_q     <= 1'b0;
            perm_q    <= 1'b0;
        end else if (ce_rise) begin
            state_q  <= ST_OPC;
            cnt_q    <= CNT_ZERO;
            id_sel_q <= '0;
            perm_q   <= (state_q == ST_WEN) || (state_q == ST_EWS);
            if (state_q == ST_WEN) wel_q <= 1'b1;
            if (state_q == ST_WRSR_DONE) begin
                sr_q  <= wr_data_q[7:2];
                wel_q <= 1'b0;
            end
        end else if (sck_rise) begin
            cnt_q   <= cnt_q + CNT_ONE;
            shreg_q <= in_byte;
            case (state_q)
                ST_OPC: begin
                    if (cnt_q == BYTE_LAST) begin
                        cnt_q <= CNT_ZERO;
                        case (in_byte)
                            OP_READ: state_q <= ST_ADDR;
                            OP_ID:   state_q <= ST_ID;
                            OP_RDSR: state_q <= ST_RDSR;
                            OP_WREN: state_q <= ST_WEN;
                            OP_EWSR: state_q <= ST_EWS;
                            OP_WRSR: state_q <= perm_q ? ST_WRSR : ST_IGNORE;
                            default: state_q <= ST_IGNORE;
                        endcase
                    end
                end
                ST_ADDR: begin
                    addr_q <= in_addr;
                    if (cnt_q == ADDR_LAST) begin
                        cnt_q   <= CNT_ZERO;
                        idx_q   <= in_addr[IDX_W-1:0];
                        state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (cnt_q == BYTE_LAST) begin
                        cnt_q <= CNT_ZERO;
                        idx_q <= idx_q + IDX_ONE;
                    end
                end
                ST_ID: begin
                    if (cnt_q == BYTE_LAST) begin
                        cnt_q    <= CNT_ZERO;
                        id_sel_q <= (id_sel_q == 2'd2) ? 2'd0 : id_sel_q + 2'd1;
                    end
                end
                ST_RDSR: begin
                    if (cnt_q == BYTE_LAST) cnt_q <= CNT_ZERO;
                end
                ST_WRSR: begin
                    if (cnt_q == BYTE_LAST) begin
                        cnt_q     <= CNT_ZERO;
                        wr_data_q <= in_byte;
                        state_q   <= ST_WRSR_DONE;
                    end
                end
                ST_WEN, ST_EWS, ST_WRSR_DONE: state_q <= ST_IGNORE;
                default: ;
            endcase
        end
    end

    // byte offered to the output driver for the current state
    always_comb begin
        case (state_q)
            ST_READ: tx_byte = mem_byte;
            ST_ID:   tx_byte = (id_sel_q == 2'd0) ? ID_MFR :
                               (id_sel_q == 2'd1) ? ID_TYPE : ID_CAP;
            ST_RDSR: tx_byte = {sr_q, wel_q, 1'b0};
            default: tx_byte = 8'h00;
        endcase
        drive_en = (state_q == ST_READ) || (state_q == ST_ID) || (state_q == ST_RDSR);
        bit_sel  = cnt_q[2:0];
        mem_idx  = idx_q;
    end

    // the latch only rises when a complete write enable ends
    assert_wel_from_wren_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> ($past(state_q) == ST_WEN && $past(ce_rise)));

    // status bits only change when a complete status write ends
    assert_status_write_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q != $past(sr_q)) |-> ($past(state_q) == ST_WRSR_DONE && $past(ce_rise)));

    // status data is only collected when permission was held at decode
    assert_wrsr_needs_permit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRSR && $past(state_q) == ST_OPC) |-> $past(perm_q));

    // while deselected the engine waits for a fresh opcode
    assert_idle_when_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_s && $past(ce_s)) |-> (state_q == ST_OPC && cnt_q == CNT_ZERO));
endmodule

// File: rtl/sfr_so_driver.sv
// sfr_so_driver: registers the outgoing bit on each falling serial clock
// while the engine offers data, and holds the drive enable until deselect.
// Assumes bit_sel counts bits already sampled by the host in this byte.
module sfr_so_driver (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_fall,
    input  logic       ce_s,
    input  logic       drive_en,
    input  logic [7:0] tx_byte,
    input  logic [2:0] bit_sel,
    output logic       so,
    output logic       so_oe
);
    // output bit and enable, released on deselect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so    <= 1'b0;
            so_oe <= 1'b0;
        end else if (ce_s) begin
            so    <= 1'b0;
            so_oe <= 1'b0;
        end else if (sck_fall && drive_en) begin
            so    <= tx_byte[3'd7 - bit_sel];
            so_oe <= 1'b1;
        end
    end

    // the data pin only moves after a falling serial clock or on deselect
    assert_so_moves_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (so != $past(so)) |-> ($past(sck_fall) || $past(ce_s)));
endmodule

// File: rtl/sflash_responder.sv
// sflash_responder: top of the serial flash command responder. It ties the
// pin front end, the command engine, the byte array and the output driver
// together. The pad ring forms the tri-state buffer from so and so_oe.
module sflash_responder #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             ce_n,
    input  logic             si,
    output logic             so,
    output logic             so_oe,
    input  logic             pl_we,
    input  logic [IDX_W-1:0] pl_addr,
    input  logic [7:0]       pl_data
);
    logic sck_rise, sck_fall, ce_rise, ce_s, si_s;
    logic [IDX_W-1:0] mem_idx;
    logic [7:0] mem_byte, tx_byte;
    logic [2:0] bit_sel;
    logic drive_en;

    sfr_bus_frontend #(.SYNC_STAGES(2)) u_frontend (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ce_n(ce_n), .si(si),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .ce_rise(ce_rise),
        .ce_s(ce_s), .si_s(si_s)
    );

    sfr_storage #(.IDX_W(IDX_W)) u_storage (
        .clk(clk), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .rd_idx(mem_idx), .rd_data(mem_byte)
    );

    sfr_cmd_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .ce_rise(ce_rise),
        .ce_s(ce_s), .si_s(si_s), .mem_byte(mem_byte), .mem_idx(mem_idx),
        .tx_byte(tx_byte), .bit_sel(bit_sel), .drive_en(drive_en)
    );

    sfr_so_driver u_driver (
        .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .ce_s(ce_s),
        .drive_en(drive_en), .tx_byte(tx_byte), .bit_sel(bit_sel),
        .so(so), .so_oe(so_oe)
    );

    // the pin is only driven while the engine is in a data-out state
    assert_hiz_outside_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && !ce_s) |-> drive_en);
endmodule

// File: tb/sflash_responder_bench.sv
module sflash_responder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_CLKS  = 6;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, ce_n = 1'b1, si = 1'b0, pl_we = 1'b0;
    logic [7:0] pl_addr = '0, pl_data = '0;
    logic so, so_oe;
    int n_chk = 0, n_fail = 0;
    bit mode3 = 1'b0;
    bit finished = 1'b0;

    sflash_responder u_sflash_responder (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ce_n(ce_n), .si(si),
        .so(so), .so_oe(so_oe), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // read vectors: {mode3, address, byte count}
    localparam logic [32:0] RD_VEC [0:5] = '{
        {1'b0, 24'h000000, 8'd4},
        {1'b0, 24'h000021, 8'd3},
        {1'b0, 24'h0000FE, 8'd4},
        {1'b0, 24'h123405, 8'd3},
        {1'b1, 24'h000080, 8'd3},
        {1'b0, 24'hFFFFFF, 8'd3}
    };

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx,
                             inout logic oe_any);
        rx = '0;
        for (int b = 7; b > 7 - n; b--) begin
            @(negedge clk); sck = 1'b0; si = tx[b];
            repeat (HALF_CLKS) @(negedge clk);
            rx[b] = so; oe_any = oe_any | so_oe;
            sck = 1'b1;
            repeat (HALF_CLKS) @(negedge clk);
        end
    endtask

    task automatic begin_cyc();
        sck = mode3;
        repeat (2) @(negedge clk);
        ce_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic end_cyc();
        repeat (2) @(negedge clk);
        if (!mode3) sck = 1'b0;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op, input int nbits);
        logic [7:0] rx; logic oe;
        oe = 1'b0;
        begin_cyc();
        xfer_bits(op, nbits > 8 ? 8 : nbits, rx, oe);
        if (nbits > 8) xfer_bits(8'hFF, nbits - 8, rx, oe);
        end_cyc();
    endtask

    task automatic read_status(output logic [7:0] st);
        logic [7:0] rx; logic oe;
        oe = 1'b0;
        begin_cyc();
        xfer_bits(8'h05, 8, rx, oe);
        xfer_bits(8'h00, 8, st, oe);
        end_cyc();
    endtask

    task automatic write_status(input logic [7:0] d, input int dbits);
        logic [7:0] rx; logic oe;
        oe = 1'b0;
        begin_cyc();
        xfer_bits(8'h01, 8, rx, oe);
        xfer_bits(d, dbits, rx, oe);
        end_cyc();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] st, rx;
        logic oe;
        // preload the array through the test port (R13)
        for (int i = 0; i < 256; i++) begin
            @(negedge clk); pl_we = 1'b1; pl_addr = 8'(i); pl_data = pat(i);
        end
        @(negedge clk); pl_we = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R12: reset state
        check("R12 so_oe after reset", {31'b0, so_oe}, 32'd0);
        read_status(st);
        check("R12 status after reset", {24'b0, st}, 32'h00);
        check("R5 so_oe after deselect", {31'b0, so_oe}, 32'd0);

        // table of reads: R1 basic, R2 wrap, R3 upper bits, R11 mode 3
        for (int v = 0; v < 6; v++) begin
            logic [23:0] a;
            int n;
            string lbl;
            mode3 = RD_VEC[v][32];
            a = RD_VEC[v][31:8];
            n = int'(RD_VEC[v][7:0]);
            lbl = mode3 ? "R11 read mode 3" : (a[23:8] != 0) ? "R3 upper address bits" :
                  (int'(a[7:0]) + n > 256) ? "R2 wrap to index 0" : "R1 read data";
            oe = 1'b0;
            begin_cyc();
            xfer_bits(8'h03, 8, rx, oe);
            xfer_bits(a[23:16], 8, rx, oe);
            xfer_bits(a[15:8], 8, rx, oe);
            xfer_bits(a[7:0], 8, rx, oe);
            check("R5 hi-Z during opcode and address", {31'b0, oe}, 32'd0);
            for (int k = 0; k < n; k++) begin
                xfer_bits(8'h00, 8, rx, oe);
                check(lbl, {24'b0, rx}, {24'b0, pat((int'(a[7:0]) + k) & 255)});
            end
            check("R1 so_oe while streaming", {31'b0, so_oe}, 32'd1);
            end_cyc();
            check("R5 so_oe after read", {31'b0, so_oe}, 32'd0);
        end
        mode3 = 1'b0;

        // R4: identification bytes, then repeat
        oe = 1'b0;
        begin_cyc();
        xfer_bits(8'h9F, 8, rx, oe);
        check("R5 hi-Z during id opcode", {31'b0, oe}, 32'd0);
        xfer_bits(8'h00, 8, rx, oe); check("R4 id byte 0", {24'b0, rx}, 32'h8C);
        xfer_bits(8'h00, 8, rx, oe); check("R4 id byte 1", {24'b0, rx}, 32'h20);
        xfer_bits(8'h00, 8, rx, oe); check("R4 id byte 2", {24'b0, rx}, 32'h13);
        xfer_bits(8'h00, 8, rx, oe); check("R4 id repeat", {24'b0, rx}, 32'h8C);
        end_cyc();

        // R5: unknown opcode keeps the pin undriven
        oe = 1'b0;
        begin_cyc();
        xfer_bits(8'hAB, 8, rx, oe);
        xfer_bits(8'h00, 8, rx, oe);
        xfer_bits(8'h00, 8, rx, oe);
        end_cyc();
        check("R5 unknown opcode stays hi-Z", {31'b0, oe}, 32'd0);

        // R6: write enable sets the latch
        cmd(8'h06, 8);
        read_status(st);
        check("R6 latch set by write enable", {24'b0, st}, 32'h02);

        // R8: status write not directly after the enable is ignored
        write_status(8'hA8, 8);
        read_status(st);
        check("R8 late status write ignored", {24'b0, st}, 32'h02);

        // R7: enable then status write, latch cleared
        cmd(8'h06, 8);
        write_status(8'hA8, 8);
        read_status(st);
        check("R7 status write after enable", {24'b0, st}, 32'hA8);

        // R9: enable-write-status does not set the latch but permits the write
        cmd(8'h50, 8);
        read_status(st);
        check("R9 latch untouched by 50h", {24'b0, st}, 32'hA8);
        cmd(8'h50, 8);
        write_status(8'h54, 8);
        read_status(st);
        check("R9 status write after 50h", {24'b0, st}, 32'h54);

        // R7: low two data bits discarded (mode 3)
        mode3 = 1'b1;
        cmd(8'h06, 8);
        write_status(8'hFF, 8);
        read_status(st);
        check("R7 R11 low bits discarded", {24'b0, st}, 32'hFC);
        mode3 = 1'b0;

        // R10: truncated and over-long write enable
        cmd(8'h06, 4);
        read_status(st);
        check("R10 partial opcode cancelled", {24'b0, st}, 32'hFC);
        cmd(8'h06, 9);
        read_status(st);
        check("R10 over-long enable cancelled", {24'b0, st}, 32'hFC);
        cmd(8'h06, 8);
        read_status(st);
        check("R10 fresh opcode after abort", {24'b0, st}, 32'hFE);

        // R8: short status write after enable leaves status
        cmd(8'h06, 8);
        write_status(8'h00, 4);
        read_status(st);
        check("R8 short status write ignored", {24'b0, st}, 32'hFE);

        // R13: preload a new byte and read it back
        @(negedge clk); pl_we = 1'b1; pl_addr = 8'h40; pl_data = 8'h5A;
        @(negedge clk); pl_we = 1'b0;
        oe = 1'b0;
        begin_cyc();
        xfer_bits(8'h03, 8, rx, oe);
        xfer_bits(8'h00, 8, rx, oe);
        xfer_bits(8'h00, 8, rx, oe);
        xfer_bits(8'h40, 8, rx, oe);
        xfer_bits(8'h00, 8, rx, oe);
        check("R13 preloaded byte", {24'b0, rx}, 32'h5A);
        end_cyc();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule